// File: doc/BRIEF.md
# Two-Level Lookahead Binary Adder

This block adds two 32-bit unsigned operands and a carry-in, and returns a 32-bit sum and a carry-out. It is purely combinational. The operand width is split into four 8-bit groups. Inside each group, every bit forms a generate term (the AND of its operand bits) and a propagate term (the OR of its operand bits). The group then expands its internal carries into sum-of-products form over those terms.

Each group also reports one generate and one propagate signal for the group as a whole. A separate second-level lookahead unit takes those four pairs and the carry-in. From them it forms the carries into groups 1, 2 and 3 and the final carry-out. No carry ripples from one group into the next. Each sum bit is the XOR of the two operand bits and the carry into that bit. The block is meant to sit on a datapath path where the carry chain must stay shallow.

Top module: `cla_adder32`

## Requirements
- R1: `sum_o` equals the low 32 bits of `a_i + b_i + cin_i`, taken as unsigned numbers.
- R2: `cout_o` equals bit 32 of the 33-bit result of `a_i + b_i + cin_i`.
- R3: Group j covers operand bits 8j+7 down to 8j. When some bit of a group produces a carry that no higher bit of that group stops, a carry enters the next group whatever carry entered the group.
- R4: When every bit of a group has at least one operand bit set and the group produces no carry of its own, the carry leaving the group equals the carry entering it. This holds across several such groups in a row.
- R5: When a group neither produces nor passes a carry, no carry enters the next group, even with a carry-in of 1 to the group.
- R6: All-ones plus a carry-in of 1 gives a sum of zero and a carry-out of 1. All-ones plus all-ones plus a carry-in of 1 gives all-ones and a carry-out of 1.
- R7: Zero plus zero with a carry-in of 0 gives a sum of zero and a carry-out of 0.
- R8: The carry that the second-level unit delivers to each group boundary equals the carry that the group below computes for its own top bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand |
| cin_i | input | 1 | Carry into bit 0 |
| sum_o | output | 32 | Low 32 bits of the sum |
| cout_o | output | 1 | Carry out of bit 31 |

## Verification
Several checks run on every input change. The full sum is compared against a plain addition. For each group, the carry that leaves it is checked against that group's generate and propagate pair: forced high, passed through, or forced low. The boundary carry that the second level delivers is checked against the carry the group computes for itself. Whether carries actually cross several group boundaries within one lookahead can only be seen in the bench's directed patterns. Those include all-ones operands, propagate runs spanning groups, and a kill group that blocks a carry-in. The bench also covers random operands.

// File: rtl/cla_pkg.sv
package cla_pkg;
  localparam int unsigned SPAN_MAX = 32;

  // Carry into position idx+1 in expanded sum-of-products form:
  // OR over k<=idx of g[k]&p[k+1..idx], plus p[0..idx]&cin.
  function automatic logic sop_carry(input logic [SPAN_MAX-1:0] g,
                                     input logic [SPAN_MAX-1:0] p,
                                     input logic cin,
                                     input int unsigned idx);
    logic acc;
    logic term;
    acc = 1'b0;
    for (int unsigned k = 0; k <= idx; k++) begin
      term = g[k];
      for (int unsigned m = k + 1; m <= idx; m++) term = term & p[m];
      acc = acc | term;
    end
    term = cin;
    for (int unsigned m = 0; m <= idx; m++) term = term & p[m];
    return acc | term;
  endfunction

  // Product of all propagate terms in positions 0..idx.
  function automatic logic all_prop(input logic [SPAN_MAX-1:0] p,
                                    input int unsigned idx);
    logic t;
    t = 1'b1;
    for (int unsigned m = 0; m <= idx; m++) t = t & p[m];
    return t;
  endfunction
endpackage

// File: rtl/cla_group.sv
module cla_group #(
  parameter int unsigned GW = 8
) (
  input  logic [GW-1:0] a_i,
  input  logic [GW-1:0] b_i,
  input  logic          cin_i,
  output logic [GW-1:0] sum_o,
  output logic          grp_gen_o,
  output logic          grp_prop_o,
  output logic          top_carry_o
);
  import cla_pkg::*;

  logic [GW-1:0]       bit_gen;
  logic [GW-1:0]       bit_prop;
  logic [GW:0]         carry;
  logic [SPAN_MAX-1:0] gen_x;
  logic [SPAN_MAX-1:0] prop_x;

  genvar i;
  generate
    for (i = 0; i < GW; i++) begin : g_bit
      assign bit_gen[i]  = a_i[i] & b_i[i];
      assign bit_prop[i] = a_i[i] | b_i[i];
    end
  endgenerate

  assign gen_x  = SPAN_MAX'(bit_gen);
  assign prop_x = SPAN_MAX'(bit_prop);
  assign carry[0] = cin_i;

  generate
    for (i = 0; i < GW; i++) begin : g_carry
      assign carry[i+1] = sop_carry(gen_x, prop_x, cin_i, i);
      assign sum_o[i]   = a_i[i] ^ b_i[i] ^ carry[i];
    end
  endgenerate

  assign grp_gen_o   = sop_carry(gen_x, prop_x, 1'b0, GW - 1);
  assign grp_prop_o  = all_prop(prop_x, GW - 1);
  assign top_carry_o = carry[GW];

  // R3/R4/R5 locally: group outputs agree with its own top carry
  always_comb begin
    if (grp_gen_o)
      a_r3_group_gen_carries: assert (top_carry_o) else $error("R3 group generate without carry");
    if (!grp_gen_o && !grp_prop_o)
      a_r5_group_kill: assert (!top_carry_o) else $error("R5 killed group produced carry");
    if (grp_prop_o && !grp_gen_o)
      a_r4_group_pass: assert (top_carry_o == cin_i) else $error("R4 propagate group mismatch");
  end
endmodule

// File: rtl/cla_lookahead.sv
module cla_lookahead #(
  parameter int unsigned NG = 4
) (
  input  logic [NG-1:0] grp_gen_i,
  input  logic [NG-1:0] grp_prop_i,
  input  logic          cin_i,
  output logic [NG:0]   bnd_carry_o
);
  import cla_pkg::*;

  logic [SPAN_MAX-1:0] gen_x;
  logic [SPAN_MAX-1:0] prop_x;

  assign gen_x  = SPAN_MAX'(grp_gen_i);
  assign prop_x = SPAN_MAX'(grp_prop_i);
  assign bnd_carry_o[0] = cin_i;

  genvar j;
  generate
    for (j = 0; j < NG; j++) begin : g_bnd
      assign bnd_carry_o[j+1] = sop_carry(gen_x, prop_x, cin_i, j);
    end
  endgenerate
endmodule

// File: rtl/cla_adder32.sv
module cla_adder32 #(
  parameter int unsigned GROUP_W = 8,
  parameter int unsigned GROUPS  = 4
) (
  input  logic [GROUP_W*GROUPS-1:0] a_i,
  input  logic [GROUP_W*GROUPS-1:0] b_i,
  input  logic                      cin_i,
  output logic [GROUP_W*GROUPS-1:0] sum_o,
  output logic                      cout_o
);
  localparam int unsigned WIDTH = GROUP_W * GROUPS;

  logic [GROUPS-1:0] grp_gen;
  logic [GROUPS-1:0] grp_prop;
  logic [GROUPS-1:0] grp_top_carry;
  logic [GROUPS:0]   bnd_carry;
  logic [WIDTH:0]    ref_total;

  genvar j;
  generate
    for (j = 0; j < GROUPS; j++) begin : g_grp
      cla_group #(.GW(GROUP_W)) u_grp (
        .a_i        (a_i[j*GROUP_W +: GROUP_W]),
        .b_i        (b_i[j*GROUP_W +: GROUP_W]),
        .cin_i      (bnd_carry[j]),
        .sum_o      (sum_o[j*GROUP_W +: GROUP_W]),
        .grp_gen_o  (grp_gen[j]),
        .grp_prop_o (grp_prop[j]),
        .top_carry_o(grp_top_carry[j])
      );
    end
  endgenerate

  cla_lookahead #(.NG(GROUPS)) u_la (
    .grp_gen_i  (grp_gen),
    .grp_prop_i (grp_prop),
    .cin_i      (cin_i),
    .bnd_carry_o(bnd_carry)
  );

  assign cout_o = bnd_carry[GROUPS];

  assign ref_total = {1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, cin_i};

  always_comb begin
    a_r1_sum_matches: assert (sum_o == ref_total[WIDTH-1:0]) else $error("R1 sum mismatch");
    a_r2_carry_out: assert (cout_o == ref_total[WIDTH]) else $error("R2 carry-out mismatch");
    for (int k = 0; k < int'(GROUPS); k++) begin
      a_r8_boundary_agrees: assert (bnd_carry[k+1] == grp_top_carry[k]) else $error("R8 boundary carry mismatch");
    end
  end
endmodule

// File: tb/cla_adder32_bench.sv
`timescale 1ns/1ps
module cla_adder32_bench;
  logic        clk = 1'b0;
  logic [31:0] a, b, sum;
  logic        cin, cout;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  cla_adder32 u_cla_adder32 (
    .a_i(a), .b_i(b), .cin_i(cin), .sum_o(sum), .cout_o(cout)
  );

  // {a, b, cin, expected sum, expected cout}
  localparam int NV = 10;
  localparam logic [97:0] VEC [NV] = '{
    {32'h00000000, 32'h00000000, 1'b0, 32'h00000000, 1'b0},
    {32'hFFFFFFFF, 32'h00000000, 1'b1, 32'h00000000, 1'b1},
    {32'hFFFFFFFF, 32'hFFFFFFFF, 1'b1, 32'hFFFFFFFF, 1'b1},
    {32'h000000FF, 32'h00000001, 1'b0, 32'h00000100, 1'b0},
    {32'h00FFFFFF, 32'h00000001, 1'b0, 32'h01000000, 1'b0},
    {32'h80000000, 32'h80000000, 1'b0, 32'h00000000, 1'b1},
    {32'h12345678, 32'h87654321, 1'b0, 32'h99999999, 1'b0},
    {32'h0000FF80, 32'h00000080, 1'b0, 32'h00010000, 1'b0},
    {32'hFFFFFF00, 32'h00000100, 1'b0, 32'h00000000, 1'b1},
    {32'h7FFFFFFF, 32'h00000001, 1'b1, 32'h80000001, 1'b0}
  };

  task automatic apply_check(input logic [31:0] ta, input logic [31:0] tb,
                             input logic tc, input logic [31:0] es,
                             input logic ec, input string req);
    @(negedge clk);
    a = ta; b = tb; cin = tc;
    #1;
    checks++;
    if (sum !== es || cout !== ec) begin
      errors++;
      $display("FAIL %s a=%h b=%h cin=%b got sum=%h cout=%b exp sum=%h cout=%b",
               req, ta, tb, tc, sum, cout, es, ec);
    end
  endtask

  task automatic ref_check(input logic [31:0] ta, input logic [31:0] tb,
                           input logic tc, input string req);
    logic [32:0] r;
    r = 33'(ta) + 33'(tb) + 33'(tc);
    apply_check(ta, tb, tc, r[31:0], r[32], req);
  endtask

  initial begin
    a = '0; b = '0; cin = 1'b0;
    // R7 idle state: zero operands
    apply_check(32'h0, 32'h0, 1'b0, 32'h0, 1'b0, "R7");
    for (int i = 0; i < NV; i++)
      apply_check(VEC[i][97:66], VEC[i][65:34], VEC[i][33], VEC[i][32:1], VEC[i][0], "R1_R2_table");
    // R6 all-ones corner cases
    apply_check(32'hFFFFFFFF, 32'h0, 1'b1, 32'h0, 1'b1, "R6");
    apply_check(32'hFFFFFFFF, 32'hFFFFFFFF, 1'b1, 32'hFFFFFFFF, 1'b1, "R6");
    // R3 group generate forces carry into group 1 regardless of cin
    apply_check(32'h00000080, 32'h00000080, 1'b0, 32'h00000100, 1'b0, "R3");
    apply_check(32'h00000080, 32'h00000080, 1'b1, 32'h00000101, 1'b0, "R3");
    apply_check(32'h00FFFF80, 32'h00000080, 1'b0, 32'h01000000, 1'b0, "R3");
    // R4 propagate groups pass the carry through multiple boundaries
    apply_check(32'h0F0F0F0F, 32'hF0F0F0F0, 1'b1, 32'h00000000, 1'b1, "R4");
    apply_check(32'h0F0F0F0F, 32'hF0F0F0F0, 1'b0, 32'hFFFFFFFF, 1'b0, "R4");
    apply_check(32'h00FFFF00, 32'h00000100, 1'b0, 32'h01000000, 1'b0, "R4");
    // R5 kill group blocks carry-in from reaching group 1
    apply_check(32'h0000FF01, 32'h00000000, 1'b1, 32'h0000FF02, 1'b0, "R5");
    apply_check(32'hFFFF0000, 32'h0000FF00, 1'b1, 32'hFFFFFF01, 1'b0, "R5");
    // R1/R2 random operands against a 33-bit addition
    for (int i = 0; i < 300; i++)
      ref_check($urandom, $urandom, 1'($urandom), "R1_R2_random");
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired before completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule